// File: doc/BRIEF.md
# I2C Target Address Matcher

This block decides whether an I2C target claims a transaction. It watches the byte or bytes that follow a START and compares them with the target's configured addresses. It then drives the acknowledge decision and reports which address matched and in which direction the transfer runs. A separate bit-level engine supplies the received byte, a byte-complete strobe, START and STOP indications, and a strobe for the rising SCL edge of the eighth bit. That engine owns the line drivers and the shift register. This block consumes its acknowledge decision and its request pulses.

There are two address modes. In the first, four independent 7-bit identities are compared at once. In the second, a single 10-bit identity is matched over two bytes, and a later read can reclaim it after a repeated START. A general call can be enabled on its own. A second enable adds a hardware general call, which compares the byte after a general call with a programmable value. General-call status is sticky and is cleared only by an explicit clear pulse or by reset. Receive, transmit, stop and repeated-START request pulses are produced; each is gated by its own interrupt enable. The receive and transmit pulses are also mirrored onto DMA request outputs when DMA is enabled.

Top module: `i2c_target_addr_match`

## Requirements
- R1: After reset, `ack_o`, `match_idx_o`, `dir_rd_o`, `gc_status_o`, `gc_id_o`, `hwgc_o`, every request pulse, `irq_o` and both DMA outputs are 0.
- R2: With `ten_mode_i` low, a first byte whose bits 7:1 equal one of the four IDs gives `ack_o`=1 one cycle after `byte_done_i`. `match_idx_o` then holds that ID's index and `dir_rd_o` holds bit 0 of the byte. ID k sits at bits 7k+6:7k of `id_list_i`. When several IDs are equal, the lowest index wins.
- R3: A first byte that matches nothing gives `ack_o`=0. Later data bytes in that transaction raise no receive or transmit request.
- R4: With `ten_mode_i` high, the first byte must be {11110, addr[9:8], 0} and the second byte must be addr[7:0]; each is acknowledged, and the match reports index 0 in the write direction. After a repeated START, the header {11110, addr[9:8], 1} is acknowledged as a read only if this transaction already matched both bytes. A wrong second byte, or a read header without that earlier match, gives `ack_o`=0.
- R5: A first byte of 0x00 is acknowledged when `gc_en_i` is high and refused when it is low. Acceptance sets `gc_status_o`=1 and `gc_id_o`=1.
- R6: With both `gc_en_i` and `hwgc_en_i` high, a byte after a general call that equals `alt_i` with bit 0 forced to 1 sets `hwgc_o`=1 and `gc_id_o`=2. With `hwgc_en_i` low, `hwgc_o` stays 0 and `gc_id_o` stays 1. The byte also raises a receive request.
- R7: `gc_status_o`, `gc_id_o` and `hwgc_o` survive STOP. A `gc_clear_i` pulse clears all three one cycle later. If a general-call event lands in the same cycle as the clear, the event wins.
- R8: While `nack_next_i` is high, a first address byte is not acknowledged, even when it matches.
- R9: In a claimed write, each data byte gives a one-cycle `rx_req_o` one cycle after `byte_done_i`. A read-address acknowledge and each transmitted read byte give a one-cycle `tx_req_o` at the same point. With early transmit off, that is the only transmit request for the read address.
- R10: With `early_tx_i` high, `dir_edge_i` during the first byte, while `rx_byte_i` holds a matching read address, gives `tx_req_o` one cycle later. The `byte_done_i` of that address then raises no second transmit request.
- R11: STOP gives a one-cycle `stop_req_o` one cycle later. It also clears `ack_o`, `match_idx_o` and `dir_rd_o`.
- R12: START while a transaction is active gives a one-cycle `rs_req_o` one cycle later. START from idle does not.
- R13: `irq_o` is high exactly while some request pulse is high and its own enable (`ie_rx_i`, `ie_tx_i`, `ie_stop_i`, `ie_rs_i`) is set. `rx_dma_o` and `tx_dma_o` follow the receive and transmit pulses while `dma_rx_en_i` and `dma_tx_en_i` are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_i | input | 8 | Byte from the shift register |
| byte_done_i | input | 1 | Byte complete strobe |
| dir_edge_i | input | 1 | Rising SCL of the eighth bit |
| start_i | input | 1 | START or repeated START seen |
| stop_i | input | 1 | STOP seen |
| id_list_i | input | 28 | Four 7-bit identities, ID k at bits 7k+6:7k |
| ten_mode_i | input | 1 | Select 10-bit addressing |
| ten_addr_i | input | 10 | The 10-bit identity |
| gc_en_i | input | 1 | Accept general call |
| hwgc_en_i | input | 1 | Enable hardware general call compare |
| alt_i | input | 8 | Hardware general call compare value (bit 0 treated as 1) |
| nack_next_i | input | 1 | Refuse the next address |
| gc_clear_i | input | 1 | Clear sticky general-call status |
| early_tx_i | input | 1 | Early transmit request mode |
| ie_rx_i | input | 1 | Receive interrupt enable |
| ie_tx_i | input | 1 | Transmit interrupt enable |
| ie_stop_i | input | 1 | Stop interrupt enable |
| ie_rs_i | input | 1 | Repeated START interrupt enable |
| dma_rx_en_i | input | 1 | Receive DMA enable |
| dma_tx_en_i | input | 1 | Transmit DMA enable |
| ack_o | output | 1 | Acknowledge decision for the last byte |
| match_idx_o | output | 2 | Index of matched identity |
| dir_rd_o | output | 1 | 1 for a read transaction |
| gc_status_o | output | 1 | Sticky general call seen |
| gc_id_o | output | 2 | 0 none, 1 general call, 2 hardware general call |
| hwgc_o | output | 1 | Sticky hardware general call seen |
| rx_req_o | output | 1 | Receive request pulse |
| tx_req_o | output | 1 | Transmit request pulse |
| stop_req_o | output | 1 | Stop request pulse |
| rs_req_o | output | 1 | Repeated START request pulse |
| irq_o | output | 1 | Gated interrupt |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_dma_o | output | 1 | Transmit DMA request |

## Verification
Every registered result is due one cycle after the strobe that causes it. This covers acknowledge, index, direction, general-call status, each request pulse and the sticky flags; `irq_o` and the DMA outputs land in that same cycle, since they are gated from the registered pulses. Each driver step records the cycle count at the edge where its strobe is captured and queues the expected values for the following cycle. The monitor compares them in mid-cycle, away from both edges. The early transmit case is queued against the `dir_edge_i` cycle. A second item against the `byte_done_i` cycle checks that no further request appears.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR2,
    ST_GCDATA,
    ST_DATA,
    ST_SKIP
  } am_state_e;

  localparam logic [1:0] GCK_NONE = 2'd0;
  localparam logic [1:0] GCK_GEN  = 2'd1;
  localparam logic [1:0] GCK_HW   = 2'd2;

  localparam logic [4:0] TEN_HDR = 5'b11110;
endpackage

// File: rtl/i2cam_id_cmp.sv
module i2cam_id_cmp #(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = 7,
  parameter int TEN_W   = 10,
  localparam int IDX_W  = $clog2(NUM_IDS)
) (
  input  logic [7:0]              byte_i,
  input  logic [NUM_IDS*ID_W-1:0] id_list_i,
  input  logic [TEN_W-1:0]        ten_addr_i,
  input  logic                    ten_mode_i,
  output logic                    hit7_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    gc_hit_o,
  output logic                    hdr_hit_o
);
  import i2cam_pkg::*;

  // lowest index wins: scan downward so the last hit kept is the smallest
  always_comb begin
    hit7_o = 1'b0;
    idx_o  = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (byte_i[7:1] == id_list_i[i*ID_W +: ID_W]) begin
        hit7_o = !ten_mode_i;
        idx_o  = IDX_W'(i);
      end
    end
  end

  assign gc_hit_o  = (byte_i == 8'h00);
  assign hdr_hit_o = ten_mode_i &&
                     (byte_i[7:1] == {TEN_HDR, ten_addr_i[TEN_W-1:TEN_W-2]});
endmodule

// File: rtl/i2cam_req_gate.sv
module i2cam_req_gate #(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] ie_i,
  input  logic               rx_req_i,
  input  logic               tx_req_i,
  input  logic               dma_rx_en_i,
  input  logic               dma_tx_en_i,
  output logic               irq_o,
  output logic               rx_dma_o,
  output logic               tx_dma_o
);
  logic [NUM_SRC-1:0] gated;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign gated[g] = req_i[g] & ie_i[g];
  end

  assign irq_o    = |gated;
  assign rx_dma_o = rx_req_i & dma_rx_en_i;
  assign tx_dma_o = tx_req_i & dma_tx_en_i;
endmodule

// File: rtl/i2c_target_addr_match.sv
module i2c_target_addr_match #(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = 7,
  parameter int TEN_W   = 10,
  localparam int IDX_W  = $clog2(NUM_IDS),
  localparam int LIST_W = NUM_IDS * ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_byte_i,
  input  logic              byte_done_i,
  input  logic              dir_edge_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [LIST_W-1:0] id_list_i,
  input  logic              ten_mode_i,
  input  logic [TEN_W-1:0]  ten_addr_i,
  input  logic              gc_en_i,
  input  logic              hwgc_en_i,
  input  logic [7:0]        alt_i,
  input  logic              nack_next_i,
  input  logic              gc_clear_i,
  input  logic              early_tx_i,
  input  logic              ie_rx_i,
  input  logic              ie_tx_i,
  input  logic              ie_stop_i,
  input  logic              ie_rs_i,
  input  logic              dma_rx_en_i,
  input  logic              dma_tx_en_i,
  output logic              ack_o,
  output logic [IDX_W-1:0]  match_idx_o,
  output logic              dir_rd_o,
  output logic              gc_status_o,
  output logic [1:0]        gc_id_o,
  output logic              hwgc_o,
  output logic              rx_req_o,
  output logic              tx_req_o,
  output logic              stop_req_o,
  output logic              rs_req_o,
  output logic              irq_o,
  output logic              rx_dma_o,
  output logic              tx_dma_o
);
  import i2cam_pkg::*;

  am_state_e        state_q;
  logic             ten_ok_q;
  logic             hit7, gc_hit, hdr_hit;
  logic [IDX_W-1:0] cmp_idx;
  logic             rw_bit;
  logic             read_hit;
  logic [7:0]       alt_cmp;

  i2cam_id_cmp #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .TEN_W(TEN_W)
  ) u_cmp (
    .byte_i     (rx_byte_i),
    .id_list_i  (id_list_i),
    .ten_addr_i (ten_addr_i),
    .ten_mode_i (ten_mode_i),
    .hit7_o     (hit7),
    .idx_o      (cmp_idx),
    .gc_hit_o   (gc_hit),
    .hdr_hit_o  (hdr_hit)
  );

  assign rw_bit   = rx_byte_i[0];
  assign alt_cmp  = alt_i | 8'h01;
  assign read_hit = rw_bit && !nack_next_i && (hit7 || (hdr_hit && ten_ok_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ten_ok_q    <= 1'b0;
      ack_o       <= 1'b0;
      match_idx_o <= '0;
      dir_rd_o    <= 1'b0;
      gc_status_o <= 1'b0;
      gc_id_o     <= GCK_NONE;
      hwgc_o      <= 1'b0;
      rx_req_o    <= 1'b0;
      tx_req_o    <= 1'b0;
      stop_req_o  <= 1'b0;
      rs_req_o    <= 1'b0;
    end else begin
      rx_req_o   <= 1'b0;
      tx_req_o   <= 1'b0;
      stop_req_o <= 1'b0;
      rs_req_o   <= 1'b0;
      // clear first so that a same-cycle general-call event overrides it
      if (gc_clear_i) begin
        gc_status_o <= 1'b0;
        gc_id_o     <= GCK_NONE;
        hwgc_o      <= 1'b0;
      end
      if (stop_i) begin
        state_q     <= ST_IDLE;
        ten_ok_q    <= 1'b0;
        ack_o       <= 1'b0;
        match_idx_o <= '0;
        dir_rd_o    <= 1'b0;
        stop_req_o  <= 1'b1;
      end else if (start_i) begin
        if (state_q != ST_IDLE) rs_req_o <= 1'b1;
        state_q <= ST_ADDR;
        ack_o   <= 1'b0;
      end else begin
        if (dir_edge_i && early_tx_i && state_q == ST_ADDR && read_hit)
          tx_req_o <= 1'b1;
        if (byte_done_i) begin
          case (state_q)
            ST_ADDR: begin
              if (nack_next_i) begin
                ack_o   <= 1'b0;
                state_q <= ST_SKIP;
              end else if (gc_hit && gc_en_i) begin
                ack_o       <= 1'b1;
                dir_rd_o    <= 1'b0;
                gc_status_o <= 1'b1;
                gc_id_o     <= GCK_GEN;
                state_q     <= ST_GCDATA;
              end else if (hit7 || (hdr_hit && rw_bit && ten_ok_q)) begin
                ack_o       <= 1'b1;
                match_idx_o <= hit7 ? cmp_idx : '0;
                dir_rd_o    <= rw_bit;
                state_q     <= ST_DATA;
                if (rw_bit && !early_tx_i) tx_req_o <= 1'b1;
              end else if (hdr_hit && !rw_bit) begin
                ack_o    <= 1'b1;
                dir_rd_o <= 1'b0;
                state_q  <= ST_ADDR2;
              end else begin
                ack_o   <= 1'b0;
                state_q <= ST_SKIP;
              end
            end
            ST_ADDR2: begin
              if (rx_byte_i == ten_addr_i[7:0]) begin
                ack_o       <= 1'b1;
                ten_ok_q    <= 1'b1;
                match_idx_o <= '0;
                state_q     <= ST_DATA;
              end else begin
                ack_o   <= 1'b0;
                state_q <= ST_SKIP;
              end
            end
            ST_GCDATA: begin
              ack_o    <= 1'b1;
              rx_req_o <= 1'b1;
              state_q  <= ST_DATA;
              if (hwgc_en_i && gc_en_i && rx_byte_i == alt_cmp) begin
                hwgc_o  <= 1'b1;
                gc_id_o <= GCK_HW;
              end
            end
            ST_DATA: begin
              if (dir_rd_o) begin
                ack_o    <= 1'b0;
                tx_req_o <= 1'b1;
              end else begin
                ack_o    <= 1'b1;
                rx_req_o <= 1'b1;
              end
            end
            default: ack_o <= 1'b0;
          endcase
        end
      end
    end
  end

  i2cam_req_gate #(.NUM_SRC(4)) u_gate (
    .req_i       ({rs_req_o, stop_req_o, tx_req_o, rx_req_o}),
    .ie_i        ({ie_rs_i, ie_stop_i, ie_tx_i, ie_rx_i}),
    .rx_req_i    (rx_req_o),
    .tx_req_i    (tx_req_o),
    .dma_rx_en_i (dma_rx_en_i),
    .dma_tx_en_i (dma_tx_en_i),
    .irq_o       (irq_o),
    .rx_dma_o    (rx_dma_o),
    .tx_dma_o    (tx_dma_o)
  );
endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker #(
  parameter int IDX_W = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  byte_done_i,
  input logic                  dir_edge_i,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  gc_clear_i,
  input logic                  nack_next_i,
  input logic                  gc_en_i,
  input logic                  hwgc_en_i,
  input i2cam_pkg::am_state_e  state_i,
  input logic                  ack_o,
  input logic [IDX_W-1:0]      match_idx_o,
  input logic                  gc_status_o,
  input logic                  hwgc_o,
  input logic                  rx_req_o,
  input logic                  tx_req_o,
  input logic                  stop_req_o,
  input logic                  rs_req_o
);
  import i2cam_pkg::*;

  assert_nack_next_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_done_i && nack_next_i && state_i == ST_ADDR && !stop_i && !start_i) |=> !ack_o);

  assert_stop_clears_R11: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (match_idx_o == '0 && !ack_o && stop_req_o));

  assert_gc_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (gc_status_o && !gc_clear_i) |=> gc_status_o);

  assert_gc_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (gc_clear_i && !byte_done_i) |=> (!gc_status_o && !hwgc_o));

  assert_hwgc_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hwgc_o) |-> $past(hwgc_en_i && gc_en_i && byte_done_i));

  assert_rx_timing_R9: assert property (@(posedge clk) disable iff (rst)
    rx_req_o |-> $past(byte_done_i));

  assert_tx_timing_R10: assert property (@(posedge clk) disable iff (rst)
    tx_req_o |-> ($past(byte_done_i) || $past(dir_edge_i)));

  assert_rs_timing_R12: assert property (@(posedge clk) disable iff (rst)
    rs_req_o |-> $past(start_i));

  assert_ack_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(byte_done_i));
endmodule

bind i2c_target_addr_match i2cam_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .byte_done_i (byte_done_i),
  .dir_edge_i  (dir_edge_i),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .gc_clear_i  (gc_clear_i),
  .nack_next_i (nack_next_i),
  .gc_en_i     (gc_en_i),
  .hwgc_en_i   (hwgc_en_i),
  .state_i     (state_q),
  .ack_o       (ack_o),
  .match_idx_o (match_idx_o),
  .gc_status_o (gc_status_o),
  .hwgc_o      (hwgc_o),
  .rx_req_o    (rx_req_o),
  .tx_req_o    (tx_req_o),
  .stop_req_o  (stop_req_o),
  .rs_req_o    (rs_req_o)
);

// File: tb/sim_i2c_target_addr_match.sv
`timescale 1ns/100ps
module sim_i2c_target_addr_match;
  localparam int F_ACK = 0, F_IDX = 1, F_DIR = 2, F_GC = 3, F_GCID = 4, F_HWGC = 5,
                 F_RXR = 6, F_TXR = 7, F_STR = 8, F_RSR = 9, F_IRQ = 10,
                 F_RXD = 11, F_TXD = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] rx_byte = 8'h00;
  logic byte_done = 0, dir_edge = 0, start = 0, stop = 0, gc_clear = 0;
  logic [27:0] id_list = {7'h78, 7'h56, 7'h34, 7'h12};
  logic ten_mode = 0, gc_en = 0, hwgc_en = 0, nack_next = 0, early_tx = 0;
  logic [9:0] ten_addr = 10'h2A5;
  logic [7:0] alt = 8'h54;
  logic ie_rx = 0, ie_tx = 0, ie_stop = 0, ie_rs = 0, dma_rx = 0, dma_tx = 0;
  logic ack, dir_rd, gc_status, hwgc, rx_req, tx_req, stop_req, rs_req, irq, rx_dma, tx_dma;
  logic [1:0] match_idx, gc_id;

  always #2.5 clk = ~clk;

  i2c_target_addr_match u0 (
    .clk(clk), .rst(rst), .rx_byte_i(rx_byte), .byte_done_i(byte_done),
    .dir_edge_i(dir_edge), .start_i(start), .stop_i(stop), .id_list_i(id_list),
    .ten_mode_i(ten_mode), .ten_addr_i(ten_addr), .gc_en_i(gc_en),
    .hwgc_en_i(hwgc_en), .alt_i(alt), .nack_next_i(nack_next),
    .gc_clear_i(gc_clear), .early_tx_i(early_tx), .ie_rx_i(ie_rx),
    .ie_tx_i(ie_tx), .ie_stop_i(ie_stop), .ie_rs_i(ie_rs),
    .dma_rx_en_i(dma_rx), .dma_tx_en_i(dma_tx), .ack_o(ack),
    .match_idx_o(match_idx), .dir_rd_o(dir_rd), .gc_status_o(gc_status),
    .gc_id_o(gc_id), .hwgc_o(hwgc), .rx_req_o(rx_req), .tx_req_o(tx_req),
    .stop_req_o(stop_req), .rs_req_o(rs_req), .irq_o(irq),
    .rx_dma_o(rx_dma), .tx_dma_o(tx_dma)
  );

  typedef struct {
    int    due;
    int    fld;
    int    exp;
    string req;
  } item_t;
  item_t sb[$];
  int cyc = 0, due = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rd(int f);
    case (f)
      F_ACK:  return int'(ack);
      F_IDX:  return int'(match_idx);
      F_DIR:  return int'(dir_rd);
      F_GC:   return int'(gc_status);
      F_GCID: return int'(gc_id);
      F_HWGC: return int'(hwgc);
      F_RXR:  return int'(rx_req);
      F_TXR:  return int'(tx_req);
      F_STR:  return int'(stop_req);
      F_RSR:  return int'(rs_req);
      F_IRQ:  return int'(irq);
      F_RXD:  return int'(rx_dma);
      default: return int'(tx_dma);
    endcase
  endfunction

  // monitor: pops items due this cycle and compares mid-cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rd(it.fld) != it.exp) begin
        fails++;
        $display("FAIL %s field %0d: got %0d expected %0d (cycle %0d)",
                 it.req, it.fld, rd(it.fld), it.exp, cyc);
      end
    end
  end

  task automatic expect_v(int f, int v, string r);
    item_t it;
    it.due = due; it.fld = f; it.exp = v; it.req = r;
    sb.push_back(it);
  endtask

  task automatic step_begin();
    @(posedge clk); #1;
    byte_done = 0; dir_edge = 0; start = 0; stop = 0; gc_clear = 0;
    due = cyc + 1;
  endtask

  task automatic send_byte(logic [7:0] b);
    step_begin(); rx_byte = b; byte_done = 1;
  endtask
  task automatic send_dir(logic [7:0] b);
    step_begin(); rx_byte = b; dir_edge = 1;
  endtask
  task automatic do_start(); step_begin(); start = 1; endtask
  task automatic do_stop();  step_begin(); stop = 1;  endtask
  task automatic do_clear(); step_begin(); gc_clear = 1; endtask
  task automatic idle();     step_begin(); endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    idle();
    expect_v(F_ACK, 0, "R1"); expect_v(F_IDX, 0, "R1"); expect_v(F_GC, 0, "R1");
    expect_v(F_GCID, 0, "R1"); expect_v(F_HWGC, 0, "R1"); expect_v(F_IRQ, 0, "R1");
    expect_v(F_RXD, 0, "R1"); expect_v(F_TXD, 0, "R1");

    // R2 write to ID2, R9 receive request, R13 gating
    ie_rx = 1; dma_rx = 1;
    do_start();  expect_v(F_RSR, 0, "R12");
    send_byte(8'hAC); expect_v(F_ACK, 1, "R2"); expect_v(F_IDX, 2, "R2"); expect_v(F_DIR, 0, "R2");
    send_byte(8'h3C); expect_v(F_RXR, 1, "R9"); expect_v(F_IRQ, 1, "R13");
                      expect_v(F_RXD, 1, "R13"); expect_v(F_ACK, 1, "R9");
    do_stop();   expect_v(F_STR, 1, "R11"); expect_v(F_IRQ, 0, "R13");
                 expect_v(F_IDX, 0, "R11"); expect_v(F_ACK, 0, "R11");

    // R9 read of ID3
    do_start();
    send_byte(8'hF1); expect_v(F_ACK, 1, "R2"); expect_v(F_IDX, 3, "R2");
                      expect_v(F_DIR, 1, "R2"); expect_v(F_TXR, 1, "R9");
    send_byte(8'h00); expect_v(F_TXR, 1, "R9"); expect_v(F_TXD, 0, "R13");
    do_stop();   expect_v(F_DIR, 0, "R11");

    // R3 unmatched
    do_start();
    send_byte(8'h20); expect_v(F_ACK, 0, "R3");
    send_byte(8'h11); expect_v(F_RXR, 0, "R3"); expect_v(F_TXR, 0, "R3");
    do_stop();

    // R8 refuse next
    nack_next = 1;
    do_start();
    send_byte(8'h24); expect_v(F_ACK, 0, "R8");
    do_stop(); nack_next = 0;

    // R10 early transmit request
    early_tx = 1; ie_tx = 1; dma_tx = 1;
    do_start();
    send_dir(8'h69);  expect_v(F_TXR, 1, "R10"); expect_v(F_IRQ, 1, "R13"); expect_v(F_TXD, 1, "R13");
    send_byte(8'h69); expect_v(F_ACK, 1, "R10"); expect_v(F_IDX, 1, "R10");
                      expect_v(F_DIR, 1, "R10"); expect_v(F_TXR, 0, "R10");
    do_stop(); early_tx = 0; ie_tx = 0; dma_tx = 0;

    // R5/R6 general call plus hardware compare, R7 sticky
    gc_en = 1; hwgc_en = 1;
    do_start();
    send_byte(8'h00); expect_v(F_ACK, 1, "R5"); expect_v(F_GC, 1, "R5"); expect_v(F_GCID, 1, "R5");
    send_byte(8'h55); expect_v(F_HWGC, 1, "R6"); expect_v(F_GCID, 2, "R6"); expect_v(F_RXR, 1, "R6");
    do_stop();   expect_v(F_GC, 1, "R7"); expect_v(F_HWGC, 1, "R7"); expect_v(F_GCID, 2, "R7");
    do_clear();  expect_v(F_GC, 0, "R7"); expect_v(F_HWGC, 0, "R7"); expect_v(F_GCID, 0, "R7");

    // R6 hardware compare disabled
    hwgc_en = 0;
    do_start();
    send_byte(8'h00); expect_v(F_GC, 1, "R5");
    send_byte(8'h55); expect_v(F_HWGC, 0, "R6"); expect_v(F_GCID, 1, "R6");
    do_stop(); do_clear();

    // R5 general call disabled
    gc_en = 0;
    do_start();
    send_byte(8'h00); expect_v(F_ACK, 0, "R5"); expect_v(F_GC, 0, "R5");
    do_stop();

    // R4 ten-bit write then repeated START read, R12
    ten_mode = 1; ie_rs = 1;
    do_start();
    send_byte(8'hF4); expect_v(F_ACK, 1, "R4");
    send_byte(8'hA5); expect_v(F_ACK, 1, "R4"); expect_v(F_IDX, 0, "R4"); expect_v(F_DIR, 0, "R4");
    do_start();       expect_v(F_RSR, 1, "R12"); expect_v(F_IRQ, 1, "R13");
    send_byte(8'hF5); expect_v(F_ACK, 1, "R4"); expect_v(F_DIR, 1, "R4"); expect_v(F_TXR, 1, "R4");
    do_stop();

    // R4 read header without earlier match, wrong low byte, 7-bit ID ignored
    do_start();
    send_byte(8'hF5); expect_v(F_ACK, 0, "R4");
    do_stop(); do_start();
    send_byte(8'hF4); expect_v(F_ACK, 1, "R4");
    send_byte(8'hA6); expect_v(F_ACK, 0, "R4");
    do_stop(); do_start();
    send_byte(8'hAC); expect_v(F_ACK, 0, "R4");
    do_stop(); ten_mode = 0;

    // R2 lowest index wins on duplicate IDs
    id_list = {7'h78, 7'h56, 7'h56, 7'h12};
    do_start();
    send_byte(8'hAC); expect_v(F_ACK, 1, "R2"); expect_v(F_IDX, 1, "R2");
    do_stop();

    idle(); idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule